// File: doc/BRIEF.md
# Masked Status Interrupt Aggregator

This block gathers single-cycle event pulses into a bank of latched status registers. Each status register has a companion mask register. The block drives one active-low interrupt pin. A small set of summary registers has one bit per status register. Each bit is set while that status register holds at least one unmasked set bit. A host reads the summaries first to locate the source, and then reads only the status registers that are flagged.

A control register holds a pin-disable bit. An interrupt handler sets this bit while it services the sources. Events keep latching and the summaries keep tracking while the pin is held inactive. All registers are reached through a plain register port: a single-cycle write strobe, and a read address that returns data combinationally. Nothing streams through the block, so the port has no handshake and no back-pressure.

Address map, with N status registers of W bits:
- Status registers sit at 0..N-1.
- Mask registers sit at N..2N-1.
- The control register sits at 2N.
- The summary registers sit at 2N+1 onwards.
- Every other address is unmapped.

Top module: `stat_irq_agg`

## Requirements
- R1: After reset every status bit, every mask bit and the disable bit read 0, and `irq_n` is 1.
- R2: An event bit that is 1 in a cycle sets the matching status bit at the next clock edge. The status bit stays set after the event input returns to 0.
- R3: Writing to a status address clears each status bit whose data bit is 1. Bits written with 0 are unchanged. If an event arrives on a bit in the same cycle that the bit is cleared, the bit remains set.
- R4: A status bit whose mask bit is 0 never drives `irq_n` low. The status bit still latches and still reads back.
- R5: While the disable bit is 0, `irq_n` is 0 exactly when some status bit and its mask bit are both 1.
- R6: Summary register i (address 2N+1+i), bit j, is 1 exactly when status register i*W+j has a set bit with its mask bit set. Bits beyond the last status register read 0.
- R7: Control bit 6 is the pin-disable bit. While it is 1, `irq_n` is held at 1, but status still latches and the summaries still update. After it is cleared, `irq_n` goes low if any unmasked status bit is still set.
- R8: Writes to summary or unmapped addresses change nothing. Reads of unmapped addresses return 0.
- R9: Mask registers read back the last value written. The control register reads back only bit 6, and all its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | NUM_REGS*REG_W | Event pulses. Bit r*REG_W+b feeds status register r, bit b |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | REG_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | REG_W | Read data for `rd_addr`, combinational |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
The bench builds the block with its defaults: 16 status registers of 8 bits each. This gives two summary registers, so the split between summary 0 and summary 1 (status registers 7 and 8) is exercised directly. The 6-bit address also leaves addresses 35 to 63 unmapped, which lets the bench test reads and writes that must be ignored. Random traffic mixes sparse events with writes to status, mask and control registers. This reaches same-cycle clear/event collisions and disable toggling across many states of the mask bank.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [2:0] {
    RGN_NONE   = 3'd0,
    RGN_STATUS = 3'd1,
    RGN_MASK   = 3'd2,
    RGN_CTRL   = 3'd3,
    RGN_INFO   = 3'd4
  } irq_region_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_agg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int N_INFO   = 2,
  parameter int ADDR_W   = 6,
  parameter int IDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output irq_region_e       region,
  output logic [IDX_W-1:0]  idx
);
  localparam int MASK_BASE = NUM_REGS;
  localparam int CTRL_ADDR = 2 * NUM_REGS;
  localparam int INFO_BASE = CTRL_ADDR + 1;
  localparam int INFO_END  = INFO_BASE + N_INFO;

  int a;
  assign a = int'(addr);

  always_comb begin
    region = RGN_NONE;
    idx    = '0;
    if (a < MASK_BASE) begin
      region = RGN_STATUS;
      idx    = IDX_W'(a);
    end else if (a < CTRL_ADDR) begin
      region = RGN_MASK;
      idx    = IDX_W'(a - MASK_BASE);
    end else if (a == CTRL_ADDR) begin
      region = RGN_CTRL;
    end else if (a < INFO_END) begin
      region = RGN_INFO;
      idx    = IDX_W'(a - INFO_BASE);
    end
  end
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ev,
  input  logic             clr_we,
  input  logic             mask_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] status,
  output logic [REG_W-1:0] mask
);
  logic [REG_W-1:0] clr_bits;
  assign clr_bits = clr_we ? wdata : '0;

  // events are OR-ed in after the clear, so a colliding event survives
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~clr_bits) | ev;
      if (mask_we) mask <= wdata;
    end
  end
endmodule

// File: rtl/irq_info_encode.sv
module irq_info_encode #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 8,
  parameter int N_INFO   = 2
) (
  input  logic [NUM_REGS*REG_W-1:0] status_flat,
  input  logic [NUM_REGS*REG_W-1:0] mask_flat,
  output logic [N_INFO*REG_W-1:0]   info_flat
);
  always_comb begin
    info_flat = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      info_flat[k] = |(status_flat[k*REG_W +: REG_W] & mask_flat[k*REG_W +: REG_W]);
    end
  end
endmodule

// File: rtl/stat_irq_agg.sv
module stat_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 8,
  parameter int DIS_BIT  = 6,
  localparam int N_INFO  = (NUM_REGS + REG_W - 1) / REG_W,
  localparam int ADDR_W  = $clog2(2 * NUM_REGS + 1 + N_INFO)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGS*REG_W-1:0] ev_in,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [REG_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [REG_W-1:0]          rd_data,
  output logic                      irq_n
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  irq_region_e           wr_region, rd_region;
  logic [IDX_W-1:0]      wr_idx, rd_idx;
  logic [NUM_REGS*REG_W-1:0] status_flat, mask_flat;
  logic [N_INFO*REG_W-1:0]   info_flat;
  logic                  dis_q;

  irq_addr_decode #(.NUM_REGS(NUM_REGS), .N_INFO(N_INFO), .ADDR_W(ADDR_W), .IDX_W(IDX_W))
    u_wr_dec (.addr(wr_addr), .region(wr_region), .idx(wr_idx));

  irq_addr_decode #(.NUM_REGS(NUM_REGS), .N_INFO(N_INFO), .ADDR_W(ADDR_W), .IDX_W(IDX_W))
    u_rd_dec (.addr(rd_addr), .region(rd_region), .idx(rd_idx));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    irq_stat_bank #(.REG_W(REG_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev_in[g*REG_W +: REG_W]),
      .clr_we  (sel && (wr_region == RGN_STATUS)),
      .mask_we (sel && (wr_region == RGN_MASK)),
      .wdata   (wr_data),
      .status  (status_flat[g*REG_W +: REG_W]),
      .mask    (mask_flat[g*REG_W +: REG_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  dis_q <= 1'b0;
    else if (wr_en && (wr_region == RGN_CTRL))   dis_q <= wr_data[DIS_BIT];
  end

  irq_info_encode #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .N_INFO(N_INFO)) u_info (
    .status_flat (status_flat),
    .mask_flat   (mask_flat),
    .info_flat   (info_flat)
  );

  assign irq_n = ~((|info_flat) & ~dis_q);

  always_comb begin
    rd_data = '0;
    case (rd_region)
      RGN_STATUS: rd_data = status_flat[int'(rd_idx)*REG_W +: REG_W];
      RGN_MASK:   rd_data = mask_flat[int'(rd_idx)*REG_W +: REG_W];
      RGN_CTRL:   rd_data[DIS_BIT] = dis_q;
      RGN_INFO:   rd_data = info_flat[int'(rd_idx)*REG_W +: REG_W];
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [REG_W-1:0]          wr_data,
  input logic [NUM_REGS*REG_W-1:0] ev_in,
  input logic [NUM_REGS*REG_W-1:0] status_flat,
  input logic [NUM_REGS*REG_W-1:0] mask_flat,
  input logic                      dis_q,
  input logic                      irq_n
);
  logic [NUM_REGS*REG_W-1:0] clr_flat;
  logic                      mask_wr;

  always_comb begin
    clr_flat = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (wr_en && int'(wr_addr) == k) clr_flat[k*REG_W +: REG_W] = wr_data;
    end
  end
  assign mask_wr = wr_en && (int'(wr_addr) >= NUM_REGS) && (int'(wr_addr) < 2 * NUM_REGS);

  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_in) |=> ((status_flat & $past(ev_in)) == $past(ev_in)));

  a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(status_flat) & ~status_flat) & ~$past(clr_flat)) == '0));

  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_flat & mask_flat) == '0) |-> irq_n);

  a_r5_unmasked_fires: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(status_flat & mask_flat)) && !dis_q) |-> !irq_n);

  a_r7_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> irq_n);

  a_r9_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_flat));
endmodule

bind stat_irq_agg irq_agg_checker #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .ev_in       (ev_in),
  .status_flat (status_flat),
  .mask_flat   (mask_flat),
  .dis_q       (dis_q),
  .irq_n       (irq_n)
);

// File: tb/stat_irq_agg_bench.sv
`timescale 1ns/1ps
module stat_irq_agg_bench;
  localparam int NR = 16;
  localparam int RW = 8;
  localparam int NI = (NR + RW - 1) / RW;
  localparam int AW = $clog2(2 * NR + 1 + NI);
  localparam int CTRL = 2 * NR;
  localparam int INFO0 = CTRL + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR*RW-1:0] ev_in = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [RW-1:0] wr_data = '0;
  logic [RW-1:0] rd_data;
  logic irq_n;

  int checks = 0, failures = 0;
  logic [RW-1:0] m_st [NR];
  logic [RW-1:0] m_mk [NR];
  logic m_dis;

  always #5 clk = ~clk;

  stat_irq_agg u_stat_irq_agg (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n));

  function automatic logic exp_irq();
    logic any = 1'b0;
    for (int k = 0; k < NR; k++) any |= |(m_st[k] & m_mk[k]);
    return !(any && !m_dis);
  endfunction

  function automatic logic [RW-1:0] exp_read(input int a);
    logic [RW-1:0] r = '0;
    if (a < NR) r = m_st[a];
    else if (a < CTRL) r = m_mk[a - NR];
    else if (a == CTRL) r[6] = m_dis;
    else if (a < INFO0 + NI) begin
      for (int j = 0; j < RW; j++) begin
        int k = (a - INFO0) * RW + j;
        if (k < NR) r[j] = |(m_st[k] & m_mk[k]);
      end
    end
    return r;
  endfunction

  function automatic string tag_of(input int a);
    if (a < NR) return "R2";
    if (a < CTRL) return "R9";
    if (a == CTRL) return "R7";
    if (a < INFO0 + NI) return "R6";
    return "R8";
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input int wa, input logic [RW-1:0] wd,
                      input logic [NR*RW-1:0] ev, input int ra);
    wr_en = w; wr_addr = AW'(wa); wr_data = wd; ev_in = ev; rd_addr = AW'(ra);
    @(posedge clk);
    for (int k = 0; k < NR; k++) begin
      logic [RW-1:0] c = (w && wa == k) ? wd : '0;
      m_st[k] = (m_st[k] & ~c) | ev[k*RW +: RW];
      if (w && wa == NR + k) m_mk[k] = wd;
    end
    if (w && wa == CTRL) m_dis = wd[6];
    @(negedge clk);
    check(irq_n === exp_irq(), m_dis ? "R7" : "R5", int'(irq_n), int'(exp_irq()));
    check(rd_data === exp_read(ra), tag_of(ra), int'(rd_data), int'(exp_read(ra)));
    wr_en = 1'b0; ev_in = '0;
  endtask

  function automatic logic [NR*RW-1:0] one_ev(input int r, input int b);
    logic [NR*RW-1:0] v = '0;
    v[r*RW + b] = 1'b1;
    return v;
  endfunction

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1EAF_2024));
    for (int k = 0; k < NR; k++) begin m_st[k] = '0; m_mk[k] = '0; end
    m_dis = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(irq_n === 1'b1, "R1", int'(irq_n), 1);
    for (int a = 0; a <= CTRL; a++) begin
      rd_addr = AW'(a); #1;
      check(rd_data === '0, "R1", int'(rd_data), 0);
    end
    // R4: masked event latches but stays quiet
    step(1'b0, 0, '0, one_ev(3, 2), 3);
    check(irq_n === 1'b1 && rd_data === 8'h04, "R4", int'(rd_data), 4);
    // R6: boundary between summary registers (status 8 -> summary 1 bit 0)
    step(1'b1, NR + 8, 8'h01, one_ev(8, 0), INFO0 + 1);
    check(rd_data === 8'h01 && irq_n === 1'b0, "R6", int'(rd_data), 1);
    step(1'b0, 0, '0, '0, INFO0);
    check(rd_data === 8'h00, "R6", int'(rd_data), 0);
    // R7: disable holds pin, status and summary keep updating
    step(1'b1, CTRL, 8'h40, '0, CTRL);
    check(irq_n === 1'b1, "R7", int'(irq_n), 1);
    step(1'b1, NR + 7, 8'h80, one_ev(7, 7), INFO0);
    check(rd_data === 8'h80 && irq_n === 1'b1, "R7", int'(rd_data), 8'h80);
    step(1'b1, CTRL, 8'h00, '0, CTRL);
    check(irq_n === 1'b0, "R7", int'(irq_n), 0);
    // R3: clear colliding with event keeps bit; write 0 leaves bits
    step(1'b1, 8, 8'h01, one_ev(8, 0), 8);
    check(rd_data === 8'h01, "R3", int'(rd_data), 1);
    step(1'b1, 8, 8'h00, '0, 8);
    check(rd_data === 8'h01, "R3", int'(rd_data), 1);
    step(1'b1, 8, 8'hFF, '0, 8);
    check(rd_data === 8'h00, "R3", int'(rd_data), 0);
    // R8: writes to summary/unmapped ignored, unmapped reads zero
    step(1'b1, INFO0, 8'hFF, '0, INFO0);
    check(rd_data === 8'h80, "R8", int'(rd_data), 8'h80);
    step(1'b1, 50, 8'hFF, '0, 50);
    check(rd_data === 8'h00, "R8", int'(rd_data), 0);
    // R9: control reads back only bit 6
    step(1'b1, CTRL, 8'hFF, '0, CTRL);
    check(rd_data === 8'h40, "R9", int'(rd_data), 8'h40);
    step(1'b1, CTRL, 8'h00, '0, CTRL);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [NR*RW-1:0] ev = '0;
      int sel, wa;
      logic w;
      for (int k = 0; k < NR; k++)
        if ($urandom_range(0, 9) == 0) ev[k*RW + $urandom_range(0, RW-1)] = 1'b1;
      sel = $urandom_range(0, 19);
      w = (sel < 12);
      if (sel < 5) wa = $urandom_range(0, NR-1);
      else if (sel < 9) wa = $urandom_range(NR, CTRL-1);
      else if (sel < 10) wa = CTRL;
      else wa = $urandom_range(INFO0, 63);
      step(w, wa, RW'($urandom), ev, $urandom_range(0, 40));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule